// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM. It takes single-beat-burst requests on a valid/ready handshake. Each request names a bank, a row, a column, a direction and an auto-precharge flag. The block turns each request into the command sequence the memory needs and drives the command, bank and address pins from registers on the rising clock edge. It keeps a table of the row held open in each bank. A request to a closed bank gets an activate first. A request to a different row gets a single-bank precharge and then an activate. A request that hits the open row goes straight to read or write.

A free-running timer raises a refresh demand at the rate needed for 2048 refreshes every 16 ms, derived from the clock frequency parameter. A pending refresh wins over user requests. If any bank is open, the block first closes all banks with one all-bank precharge, then issues the refresh. After every command a single wait counter inserts the NOP cycles that the timing parameters call for. The block issues the next command in the first cycle that the counter allows.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While rst_ni is low, cke_o is 0 and cs_no is 1. From the first clock edge after reset, cke_o stays 1.
- R2: The pins encode commands as {ras_no,cas_no,we_no} with cs_no low: activate 011, read 101, write 100, precharge 010, refresh 001. An idle cycle drives cs_no high with all three strobes high.
- R3: A request to a closed bank first produces an activate to that bank, with the request row on addr_o[10:0] and the bank on ba_o.
- R4: A read or write carries the column on addr_o[7:0], the auto-precharge flag on addr_o[8], and zeros on addr_o[10:9]. It goes only to a bank whose open row equals the request row. With the flag set, the bank counts as closed afterwards.
- R5: A request to an open bank holding a different row produces a precharge of that bank alone (addr_o[8] low) before its activate.
- R6: When a refresh is due while any bank is open, the block issues a precharge with addr_o[8] high, which closes every bank. The next command after it is the refresh.
- R7: A refresh is issued only when every bank is closed.
- R8: Refreshes come from a timer of period CLK_MHZ*16000/2048 cycles. Successive refreshes lie within a bounded slack of that period.
- R9: A due refresh takes priority over user requests. No request is accepted while a refresh is pending and the command slot is free.
- R10: Minimum cycles from one command to the next:
  - activate: T_RCD
  - precharge: T_RP
  - refresh: T_RFC
  - read: CAS_LAT+BURST_LEN/2
  - write: BURST_LEN/2+T_WR
  - read or write with auto-precharge: T_RP more than the plain read or write
- R11: req_ready_o is high only with req_valid_i. Each accepted request yields exactly one read or write, in acceptance order, with the matching bank and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle (read/write issued) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bank_i | input | BANK_W | Request bank |
| req_row_i | input | ROW_W | Request row |
| req_col_i | input | COL_W | Request column |
| req_ap_i | input | 1 | Auto-precharge after the access |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BANK_W | Bank select |
| addr_o | output | ROW_W | Address bus |

## Verification
The refresh deadline and a row-hit user request can both be ready in the same free cycle. The sequencer must then pick the refresh and, if banks are open, route it through the all-bank precharge. The bench provokes this by streaming randomized back-to-back traffic, dense in row hits, across several refresh periods with a shortened refresh interval. It judges the outcome by bounding the spacing between refreshes in both directions and by checking that a refresh follows an all-bank precharge directly. It also checks every read and write against an in-order queue of accepted requests and a bank model built only from the observed pins.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010,
    CMD_REF = 3'b001
  } cmd_e;

  function automatic int max_i(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_wait_cnt.sv
module ddr_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i - 1'b1;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // R10: no command loaded while a spacing window is still open
  p_load_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);

  p_load_nonzero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0));

endmodule

// File: rtl/ddr_ref_timer.sv
module ddr_ref_timer #(
  parameter int INTERVAL = 781
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic pend_o
);

  localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;
  logic          tick;
  logic          pend_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)       pend_q <= 1'b1;
      else if (clr_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R8: a raised demand stays until a refresh is issued
  p_pend_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);

  p_clr_pending_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> pend_o);

endmodule

// File: rtl/ddr_bank_table.sv
module ddr_bank_table #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic              act_i,
  input  logic              pre_one_i,
  input  logic              pre_all_i,
  input  logic              close_i,
  output logic              open_o,
  output logic              hit_o,
  output logic              any_open_o
);

  localparam int NB = 1 << BANK_W;

  logic [NB-1:0]    open_vec;
  logic [ROW_W-1:0] row_arr [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             open_b;
    logic [ROW_W-1:0] row_b;
    logic             sel;

    assign sel = (bank_i == BANK_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_b <= 1'b0;
        row_b  <= '0;
      end else if (pre_all_i || (sel && (pre_one_i || close_i))) begin
        open_b <= 1'b0;
      end else if (sel && act_i) begin
        open_b <= 1'b1;
        row_b  <= row_i;
      end
    end

    assign open_vec[b] = open_b;
    assign row_arr[b]  = row_b;
  end

  assign open_o     = open_vec[bank_i];
  assign hit_o      = open_o && (row_arr[bank_i] == row_i);
  assign any_open_o = |open_vec;

  // R3: activate only into a closed bank
  p_act_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_o);

  // R5: single-bank precharge only on a row miss
  p_pre_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_one_i |-> (open_o && !hit_o));

  // R4: auto-precharge only accompanies a row hit
  p_close_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |-> hit_o);

  // R6: all-bank precharge leaves nothing open
  p_pre_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_all_i |=> !any_open_o);

endmodule

// File: rtl/ddr_cmd_seq.sv
module ddr_cmd_seq
  import ddr_seq_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int AP_BIT    = 8,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RFC     = 10,
  parameter int CLK_MHZ   = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              req_ap_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o
);

  localparam int RD_GAP  = CAS_LAT + BURST_LEN / 2;
  localparam int WR_GAP  = BURST_LEN / 2 + T_WR;
  localparam int GAP_MAX = max_i(max_i(RD_GAP, WR_GAP) + T_RP,
                                 max_i(T_RFC, max_i(T_RCD, T_RP)));
  localparam int CNT_W   = $clog2(GAP_MAX + 1);
  localparam int REF_INT = (CLK_MHZ * 16000) / 2048;

  localparam logic [CNT_W-1:0] G_RP  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] G_RCD = CNT_W'(T_RCD);
  localparam logic [CNT_W-1:0] G_RFC = CNT_W'(T_RFC);
  localparam logic [CNT_W-1:0] G_RD  = CNT_W'(RD_GAP);
  localparam logic [CNT_W-1:0] G_WR  = CNT_W'(WR_GAP);

  logic busy, ref_pend;
  logic tbl_open, tbl_hit, any_open;
  logic act_en, pre_one, pre_all, close_en, ref_clr, load_en;

  cmd_e              cmd_d, cmd_q;
  logic [BANK_W-1:0] ba_d, ba_q;
  logic [ROW_W-1:0]  addr_d, addr_q;
  logic [CNT_W-1:0]  gap_d;
  logic              cke_q;

  ddr_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_en),
    .val_i  (gap_d),
    .busy_o (busy)
  );

  ddr_ref_timer #(.INTERVAL(REF_INT)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ref_clr),
    .pend_o (ref_pend)
  );

  ddr_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bank_i     (req_bank_i),
    .row_i      (req_row_i),
    .act_i      (act_en),
    .pre_one_i  (pre_one),
    .pre_all_i  (pre_all),
    .close_i    (close_en),
    .open_o     (tbl_open),
    .hit_o      (tbl_hit),
    .any_open_o (any_open)
  );

  always_comb begin
    cmd_d       = CMD_NOP;
    ba_d        = '0;
    addr_d      = '0;
    gap_d       = '0;
    req_ready_o = 1'b0;
    act_en      = 1'b0;
    pre_one     = 1'b0;
    pre_all     = 1'b0;
    close_en    = 1'b0;
    ref_clr     = 1'b0;
    if (!busy) begin
      if (ref_pend) begin
        if (any_open) begin
          cmd_d          = CMD_PRE;
          addr_d[AP_BIT] = 1'b1;
          gap_d          = G_RP;
          pre_all        = 1'b1;
        end else begin
          cmd_d   = CMD_REF;
          gap_d   = G_RFC;
          ref_clr = 1'b1;
        end
      end else if (req_valid_i) begin
        ba_d = req_bank_i;
        if (!tbl_open) begin
          cmd_d  = CMD_ACT;
          addr_d = req_row_i;
          gap_d  = G_RCD;
          act_en = 1'b1;
        end else if (!tbl_hit) begin
          cmd_d   = CMD_PRE;
          gap_d   = G_RP;
          pre_one = 1'b1;
        end else begin
          cmd_d                 = req_write_i ? CMD_WR : CMD_RD;
          addr_d[COL_W-1:0]     = req_col_i;
          addr_d[AP_BIT]        = req_ap_i;
          gap_d                 = (req_write_i ? G_WR : G_RD) + (req_ap_i ? G_RP : '0);
          close_en              = req_ap_i;
          req_ready_o           = 1'b1;
        end
      end
    end
  end

  assign load_en = (cmd_d != CMD_NOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      cke_q  <= 1'b1;
    end
  end

  assign cke_o                    = cke_q;
  assign cs_no                    = (cmd_q == CMD_NOP);
  assign {ras_no, cas_no, we_no}  = cmd_q;
  assign ba_o                     = ba_q;
  assign addr_o                   = addr_q;

  // R11: acceptance only against a present request
  p_ready_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> req_valid_i);

  // R7: refresh only with every bank closed
  p_ref_closed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_d == CMD_REF) |-> !any_open);

  // R9: pending refresh blocks acceptance
  p_ref_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pend && !busy) |-> !req_ready_o);

  // R1: clock enable stays high once out of reset
  p_cke_stay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cke_o) |-> cke_o);

endmodule

// File: tb/ddr_cmd_seq_tb_top.sv
module ddr_cmd_seq_tb_top;

  localparam int CAS_LAT   = 3;
  localparam int BURST_LEN = 4;
  localparam int T_WR      = 2;
  localparam int T_RP      = 3;
  localparam int T_RCD     = 3;
  localparam int T_RFC     = 10;
  localparam int CLK_MHZ   = 20;
  localparam int RD_GAP    = CAS_LAT + BURST_LEN / 2;
  localparam int WR_GAP    = BURST_LEN / 2 + T_WR;
  localparam int REF_INT   = CLK_MHZ * 16000 / 2048;
  localparam int SLACK     = RD_GAP + WR_GAP + 2 * T_RP + 4;
  localparam int N_REQ     = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cur_v = 1'b0, cur_w = 1'b0, cur_ap = 1'b0;
  logic [1:0]  cur_b = '0;
  logic [10:0] cur_r = '0;
  logic [7:0]  cur_c = '0;
  logic        ready, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [10:0] addr;

  always #5 clk = ~clk;

  ddr_cmd_seq #(
    .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN), .T_WR(T_WR), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_RFC(T_RFC), .CLK_MHZ(CLK_MHZ)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(cur_v), .req_ready_o(ready), .req_write_i(cur_w),
    .req_bank_i(cur_b), .req_row_i(cur_r), .req_col_i(cur_c), .req_ap_i(cur_ap),
    .cke_o(cke), .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .ba_o(ba), .addr_o(addr)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, last_cyc = -100, last_gap = 0, last_ref = 0, n_ref = 0;
  int n_gen = 0, n_done = 0, head = 0, tail = 0, stall = 0;
  bit need_new = 1'b1, exp_ref = 1'b0, hung = 1'b0;
  bit          m_open [4];
  logic [10:0] m_row  [4];
  logic [1:0]  qb [1024];
  logic [10:0] qr [1024];
  logic [7:0]  qc [1024];
  bit          qw [1024];
  bit          qa [1024];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [10:0] pick_row();
    case ($urandom % 4)
      0: return 11'd0;
      1: return 11'd1;
      2: return 11'd2047;
      default: return 11'($urandom);
    endcase
  endfunction

  task automatic gen(input int k);
    case (k)
      0: begin cur_w = 0; cur_b = 0; cur_r = 5;    cur_c = 10;  cur_ap = 0; end
      1: begin cur_w = 1; cur_b = 0; cur_r = 5;    cur_c = 11;  cur_ap = 0; end
      2: begin cur_w = 0; cur_b = 0; cur_r = 7;    cur_c = 0;   cur_ap = 0; end
      3: begin cur_w = 1; cur_b = 0; cur_r = 7;    cur_c = 255; cur_ap = 1; end
      4: begin cur_w = 0; cur_b = 0; cur_r = 7;    cur_c = 1;   cur_ap = 0; end
      5: begin cur_w = 1; cur_b = 3; cur_r = 2047; cur_c = 255; cur_ap = 0; end
      6: begin cur_w = 0; cur_b = 1; cur_r = 0;    cur_c = 0;   cur_ap = 0; end
      7: begin cur_w = 0; cur_b = 3; cur_r = 0;    cur_c = 3;   cur_ap = 1; end
      default: begin
        cur_w  = 1'($urandom);
        cur_b  = 2'($urandom);
        cur_r  = pick_row();
        cur_c  = 8'($urandom);
        cur_ap = ($urandom % 4) == 0;
      end
    endcase
  endtask

  task automatic monitor();
    logic [2:0] c;
    int gap;
    chk(cke == 1'b1, "R1", cke, 1);
    c = {ras_n, cas_n, we_n};
    if (cs_n) begin
      chk(c == 3'b111, "R2", c, 3'b111);
      return;
    end
    chk(cyc - last_cyc >= last_gap, "R10", cyc - last_cyc, last_gap);
    if (exp_ref) chk(c == 3'b001, "R6", c, 3'b001);
    gap = 0;
    case (c)
      3'b001: begin
        chk(!(m_open[0] || m_open[1] || m_open[2] || m_open[3]), "R7", 1, 0);
        chk(cyc - last_ref <= REF_INT + SLACK, "R9", cyc - last_ref, REF_INT + SLACK);
        chk(cyc - last_ref >= REF_INT - SLACK, "R8", cyc - last_ref, REF_INT - SLACK);
        last_ref = cyc; n_ref++; exp_ref = 0; gap = T_RFC;
      end
      3'b011: begin
        chk(!m_open[ba], "R3", m_open[ba], 0);
        chk(ba == cur_b, "R3", ba, cur_b);
        chk(addr == cur_r, "R3", addr, cur_r);
        m_open[ba] = 1; m_row[ba] = addr; gap = T_RCD;
      end
      3'b010: begin
        gap = T_RP;
        if (addr[8]) begin
          for (int i = 0; i < 4; i++) m_open[i] = 0;
          exp_ref = 1;
        end else begin
          chk(ba == cur_b, "R5", ba, cur_b);
          chk(m_open[ba] && m_row[ba] != cur_r, "R5", m_row[ba], cur_r);
          m_open[ba] = 0;
        end
      end
      3'b101, 3'b100: begin
        chk(head != tail, "R11", head, tail);
        if (head != tail) begin
          chk(ba == qb[head], "R11", ba, qb[head]);
          chk((c == 3'b100) == qw[head], "R11", c == 3'b100, qw[head]);
          chk(addr[7:0] == qc[head], "R4", addr[7:0], qc[head]);
          chk(addr[8] == qa[head], "R4", addr[8], qa[head]);
          chk(addr[10:9] == 2'b00, "R4", addr[10:9], 0);
          chk(m_open[ba] && m_row[ba] == qr[head], "R4", m_row[ba], qr[head]);
          if (qa[head]) m_open[ba] = 0;
          gap = ((c == 3'b100) ? WR_GAP : RD_GAP) + (qa[head] ? T_RP : 0);
          head++; n_done++;
        end
      end
      default: chk(1'b0, "R2", c, 3'b111);
    endcase
    last_cyc = cyc; last_gap = gap;
  endtask

  task automatic drive();
    if (need_new) begin
      if (cur_v && ($urandom % 5) == 0) cur_v = 0;
      else if (n_gen < N_REQ) begin
        gen(n_gen); n_gen++; need_new = 0; cur_v = 1;
      end else cur_v = 0;
    end
    #1;
    chk(cur_v || !ready, "R11", ready, 0);
    if (cur_v && ready) begin
      qb[tail] = cur_b; qr[tail] = cur_r; qc[tail] = cur_c;
      qw[tail] = cur_w; qa[tail] = cur_ap; tail++;
      need_new = 1;
    end
    if (cur_v && !ready) stall++; else stall = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) begin m_open[i] = 0; m_row[i] = '0; end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cke == 1'b0, "R1", cke, 0);
      chk(cs_n == 1'b1, "R1", cs_n, 1);
    end
    rst_n = 1'b1;
    while (!(n_gen == N_REQ && need_new && n_done == N_REQ)) begin
      @(negedge clk); cyc++;
      monitor();
      drive();
      if (stall > 3000 || cyc > 150000) begin
        chk(1'b0, "R11 watchdog", stall, 0);
        hung = 1'b1;
        break;
      end
    end
    if (!hung) begin
      for (int i = 0; i < 3 * REF_INT; i++) begin
        @(negedge clk); cyc++;
        monitor();
      end
      chk(n_done == N_REQ, "R11", n_done, N_REQ);
      chk(cyc - last_ref <= REF_INT + SLACK, "R9", cyc - last_ref, REF_INT + SLACK);
      chk(n_ref >= cyc / REF_INT - 1, "R8", n_ref, cyc / REF_INT - 1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule